// File: doc/BRIEF.md
# DDR2 Power-Up Bring-Up Sequencer

This block replaces firmware in bringing a DDR2 controller and its PHY from reset to a usable state. After a `start` pulse it walks a fixed script of 18 register writes. The script first enables the PHY clock, then resets the PHY and starts its calibration. Next it issues twelve DDR2 commands through the controller's command register. Last, it loads the timing, latency and configuration registers. A guard delay of `WAIT_CYCLES` clock cycles follows each power-up step and each command. The default of 10000 cycles gives about 200 µs at 50 MHz.

Each write goes out on a valid/ready master port. A write is taken on a rising edge where both `wr_valid` and `wr_ready` are high. The slave may hold `wr_ready` low for any number of cycles, and this back-pressure only stretches the sequence. While the sequencer waits, it keeps `wr_valid` high and holds the address and data steady. It never withdraws a write once offered. The guard delay starts only after the write is taken. When the last write is taken, the block pulses `done_pulse` once and holds `init_done` high until reset.

Top module: `ddr_bringup_seq`

## Requirements
- R1: After synchronous reset, `wr_valid`, `done_pulse` and `init_done` are low, and no write is offered until `start` is seen high.
- R2: The first write goes to `A_PHY_CFG` with data 0x00000001 (bit 0 = PHY clock enable).
- R3: Two writes to `A_PHY_CTRL` follow, with no guard delay between them. The first is 0x00000003 (bit 0 = PHY reset, bit 1 = calibration reset). The second is 0x00000004 (bit 2 = calibration start).
- R4: Next come twelve writes to `A_CMD`. Each data word is {8'h00, opcode[7:0], argument[15:0]}. They run in this order: deselect 0x0F/0; precharge 0x02/0x0400; EMRS2 0x12/0; EMRS3 0x13/0; EMRS 0x11/0x0001; MRS 0x10/0x0100; precharge 0x02/0x0400; refresh 0x01/0; refresh 0x01/0; MRS 0x10/mode; EMRS 0x11/0x0381; EMRS 0x11/final.
- R5: In R4, mode is `MODE_WORD[15:0]`, and final is 0x0001 OR `MODE_WORD[31:16]`.
- R6: A guard delay follows the PHY clock write, the calibration start write and every command write. After each of these is taken, `wr_valid` stays low for exactly `WAIT_CYCLES` cycles. With `wr_ready` held high, the two writes are taken `WAIT_CYCLES`+1 cycles apart. Writes that have no guard delay are offered in the cycle right after the previous write is taken.
- R7: The script ends with three writes, each one cycle after the last is taken: `TIMING_WORD` to `A_TIMING`, `LATENCY_WORD` to `A_LATENCY`, then `CONFIG_WORD` to `A_CONFIG`.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R9: `done_pulse` is high for exactly one cycle, the cycle after the configuration write is taken. From that cycle on, `init_done` stays high and no further write is offered until reset.
- R10: `start` has no effect while a sequence runs or after it has completed.
- R11: A synchronous reset in the middle of a sequence returns the block to idle. The next `start` replays the script from the first write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the bring-up script (acted on only when idle) |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Slave takes the write this cycle |
| wr_addr | output | ADDR_W | Register address of the offered write |
| wr_data | output | 32 | Data of the offered write |
| done_pulse | output | 1 | One-cycle pulse after the final write |
| init_done | output | 1 | Level, high once the script has completed |

## Verification
The bench runs the whole script with `WAIT_CYCLES` set to 4 and compares every write, field by field, with values built from the opcode and argument encodings. It runs the script twice: once with `wr_ready` tied high, to pin exact gaps, and once with back-pressure on two of every three cycles. An off-by-one in the guard timer shows up as a gap of 4 or 6 instead of 5. A misplaced step or a wrongly packed opcode changes a data word. A sequencer that advances without waiting for `ready`, or drops `valid` under back-pressure, breaks the trace or the hold check. `start` pulses during the run and after completion catch a block that re-enters its script. A reset after the sixth write catches one that resumes mid-script instead of starting again.

// File: rtl/ddr_bringup_pkg.sv
package ddr_bringup_pkg;

  localparam int STEPS  = 18;
  localparam int STEP_W = $clog2(STEPS);

  // DDR2 command opcodes (bits 23:16 of a command word)
  localparam logic [7:0] OPC_REFRESH  = 8'h01;
  localparam logic [7:0] OPC_PRECHG   = 8'h02;
  localparam logic [7:0] OPC_DESELECT = 8'h0F;
  localparam logic [7:0] OPC_MRS      = 8'h10;
  localparam logic [7:0] OPC_EMRS1    = 8'h11;
  localparam logic [7:0] OPC_EMRS2    = 8'h12;
  localparam logic [7:0] OPC_EMRS3    = 8'h13;

  // Command arguments (bits 15:0)
  localparam logic [15:0] ARG_ALL_BANKS = 16'h0400;
  localparam logic [15:0] ARG_DLL_ON    = 16'h0001;
  localparam logic [15:0] ARG_DLL_RESET = 16'h0100;
  localparam logic [15:0] ARG_OCD_DFLT  = 16'h0380;
  localparam logic [15:0] ARG_OCD_EXIT  = 16'h0000;

  // PHY register bit positions
  localparam int PHY_CLK_EN_BIT = 0;
  localparam int PHY_RST_BIT    = 0;
  localparam int CAL_RST_BIT    = 1;
  localparam int CAL_GO_BIT     = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} seq_state_t;

  typedef enum logic [2:0] {
    TGT_PHY_CFG, TGT_PHY_CTRL, TGT_CMD, TGT_TIMING, TGT_LATENCY, TGT_CONFIG
  } target_t;

  function automatic logic [31:0] pack_cmd(input logic [7:0] op, input logic [15:0] arg);
    return {8'h00, op, arg};
  endfunction

endpackage

// File: rtl/bringup_script_rom.sv
module bringup_script_rom
  import ddr_bringup_pkg::*;
#(
  parameter logic [31:0] MODE_WORD    = 32'h0040_0B63,
  parameter logic [31:0] TIMING_WORD  = 32'h1234_5678,
  parameter logic [31:0] LATENCY_WORD = 32'h0000_0033,
  parameter logic [31:0] CONFIG_WORD  = 32'h0000_0A5C
) (
  input  logic [STEP_W-1:0] idx,
  output target_t           tgt,
  output logic [31:0]       data,
  output logic              has_wait,
  output logic              is_last
);

  localparam logic [15:0] MODE_LO = MODE_WORD[15:0];
  localparam logic [15:0] MODE_HI = MODE_WORD[31:16];

  always_comb begin
    tgt      = TGT_CMD;
    data     = '0;
    has_wait = 1'b1;
    is_last  = 1'b0;
    case (idx)
      5'd0:  begin tgt = TGT_PHY_CFG;  data = 32'(1) << PHY_CLK_EN_BIT; end
      5'd1:  begin tgt = TGT_PHY_CTRL; has_wait = 1'b0;
                   data = (32'(1) << PHY_RST_BIT) | (32'(1) << CAL_RST_BIT); end
      5'd2:  begin tgt = TGT_PHY_CTRL; data = 32'(1) << CAL_GO_BIT; end
      5'd3:  data = pack_cmd(OPC_DESELECT, 16'h0000);
      5'd4:  data = pack_cmd(OPC_PRECHG, ARG_ALL_BANKS);
      5'd5:  data = pack_cmd(OPC_EMRS2, 16'h0000);
      5'd6:  data = pack_cmd(OPC_EMRS3, 16'h0000);
      5'd7:  data = pack_cmd(OPC_EMRS1, ARG_DLL_ON);
      5'd8:  data = pack_cmd(OPC_MRS, ARG_DLL_RESET);
      5'd9:  data = pack_cmd(OPC_PRECHG, ARG_ALL_BANKS);
      5'd10: data = pack_cmd(OPC_REFRESH, 16'h0000);
      5'd11: data = pack_cmd(OPC_REFRESH, 16'h0000);
      5'd12: data = pack_cmd(OPC_MRS, MODE_LO);
      5'd13: data = pack_cmd(OPC_EMRS1, ARG_OCD_DFLT | ARG_DLL_ON);
      5'd14: data = pack_cmd(OPC_EMRS1, ARG_OCD_EXIT | ARG_DLL_ON | MODE_HI);
      5'd15: begin tgt = TGT_TIMING;  data = TIMING_WORD;  has_wait = 1'b0; end
      5'd16: begin tgt = TGT_LATENCY; data = LATENCY_WORD; has_wait = 1'b0; end
      default: begin tgt = TGT_CONFIG; data = CONFIG_WORD; has_wait = 1'b0; is_last = 1'b1; end
    endcase
  end

endmodule

// File: rtl/bringup_wait_timer.sv
module bringup_wait_timer #(
  parameter int WAIT_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expired
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (arm) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign expired = active && (cnt == LAST);

  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst) active |-> cnt <= LAST);
  // R6
  wait_rearm_chk: assert property (@(posedge clk) disable iff (rst) arm |-> !active);

endmodule

// File: rtl/ddr_bringup_seq.sv
module ddr_bringup_seq
  import ddr_bringup_pkg::*;
#(
  parameter int ADDR_W                    = 12,
  parameter int WAIT_CYCLES               = 10000,
  parameter logic [ADDR_W-1:0] A_PHY_CFG  = 12'h010,
  parameter logic [ADDR_W-1:0] A_PHY_CTRL = 12'h014,
  parameter logic [ADDR_W-1:0] A_CMD      = 12'h020,
  parameter logic [ADDR_W-1:0] A_TIMING   = 12'h030,
  parameter logic [ADDR_W-1:0] A_LATENCY  = 12'h034,
  parameter logic [ADDR_W-1:0] A_CONFIG   = 12'h038,
  parameter logic [31:0] MODE_WORD        = 32'h0040_0B63,
  parameter logic [31:0] TIMING_WORD      = 32'h1234_5678,
  parameter logic [31:0] LATENCY_WORD     = 32'h0000_0033,
  parameter logic [31:0] CONFIG_WORD      = 32'h0000_0A5C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              done_pulse,
  output logic              init_done
);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic              done_q;
  target_t           tgt;
  logic              has_wait, is_last, expired, accept, arm;

  bringup_script_rom #(
    .MODE_WORD(MODE_WORD), .TIMING_WORD(TIMING_WORD),
    .LATENCY_WORD(LATENCY_WORD), .CONFIG_WORD(CONFIG_WORD)
  ) u_rom (
    .idx(step), .tgt(tgt), .data(wr_data), .has_wait(has_wait), .is_last(is_last)
  );

  bringup_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .arm(arm), .expired(expired)
  );

  assign accept = (state == ST_ISSUE) && wr_ready;
  assign arm    = accept && has_wait && !is_last;

  always_comb begin
    case (tgt)
      TGT_PHY_CFG:  wr_addr = A_PHY_CFG;
      TGT_PHY_CTRL: wr_addr = A_PHY_CTRL;
      TGT_CMD:      wr_addr = A_CMD;
      TGT_TIMING:   wr_addr = A_TIMING;
      TGT_LATENCY:  wr_addr = A_LATENCY;
      default:      wr_addr = A_CONFIG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      step   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_ISSUE;
          step  <= '0;
        end
        ST_ISSUE: if (wr_ready) begin
          if (is_last) begin
            state  <= ST_DONE;
            done_q <= 1'b1;
          end else begin
            step <= step + 1'b1;
            if (has_wait) state <= ST_WAIT;
          end
        end
        ST_WAIT: if (expired) state <= ST_ISSUE;
        default: state <= ST_DONE;
      endcase
    end
  end

  assign wr_valid   = (state == ST_ISSUE);
  assign done_pulse = done_q;
  assign init_done  = (state == ST_DONE);

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R9
  done_once_chk: assert property (@(posedge clk) disable iff (rst) done_pulse |=> !done_pulse);
  // R9
  done_level_chk: assert property (@(posedge clk) disable iff (rst) done_pulse |-> init_done);
  // R9
  done_stick_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done && !wr_valid);
  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (rst) step < STEP_W'(STEPS));

endmodule

// File: tb/tb_ddr_bringup_seq.sv
module tb_ddr_bringup_seq;

  localparam int W = 4;
  localparam int N = 18;
  localparam logic [11:0] AP_CFG = 12'h010, AP_CTL = 12'h014, AC = 12'h020;
  localparam logic [11:0] AT = 12'h030, AL = 12'h034, AG = 12'h038;
  localparam logic [31:0] MODE = 32'h0040_0B63, TIM = 32'h1234_5678;
  localparam logic [31:0] LAT = 32'h0000_0033, CFGW = 32'h0000_0A5C;

  logic clk = 0, rst = 1, start = 0;
  logic wr_valid, wr_ready, done_pulse, init_done;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  int cyc = 0, mode = 0;
  bit mon_on = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign wr_ready = (mode == 0) ? 1'b1 : (cyc % 3 == 0);

  ddr_bringup_seq #(
    .ADDR_W(12), .WAIT_CYCLES(W),
    .A_PHY_CFG(AP_CFG), .A_PHY_CTRL(AP_CTL), .A_CMD(AC),
    .A_TIMING(AT), .A_LATENCY(AL), .A_CONFIG(AG),
    .MODE_WORD(MODE), .TIMING_WORD(TIM), .LATENCY_WORD(LAT), .CONFIG_WORD(CFGW)
  ) dut (.*);

  function automatic logic [31:0] cw(input logic [7:0] op, input logic [15:0] a);
    return (32'(op) << 16) | 32'(a);
  endfunction

  function automatic logic [11:0] exp_addr(input int i);
    if (i == 0) return AP_CFG;
    if (i <= 2) return AP_CTL;
    if (i <= 14) return AC;
    if (i == 15) return AT;
    if (i == 16) return AL;
    return AG;
  endfunction

  function automatic logic [31:0] exp_data(input int i);
    case (i)
      0: return 32'h1;
      1: return 32'h3;
      2: return 32'h4;
      3: return cw(8'h0F, 16'h0);
      4: return cw(8'h02, 16'h0400);
      5: return cw(8'h12, 16'h0);
      6: return cw(8'h13, 16'h0);
      7: return cw(8'h11, 16'h0001);
      8: return cw(8'h10, 16'h0100);
      9: return cw(8'h02, 16'h0400);
      10: return cw(8'h01, 16'h0);
      11: return cw(8'h01, 16'h0);
      12: return cw(8'h10, MODE[15:0]);
      13: return cw(8'h11, 16'h0381);
      14: return cw(8'h11, 16'h0001 | MODE[31:16]);
      15: return TIM;
      16: return LAT;
      default: return CFGW;
    endcase
  endfunction

  function automatic bit step_waits(input int i);
    return (i == 0) || (i >= 2 && i <= 14);
  endfunction

  // monitor: owns its own counters
  int mchk = 0, mfail = 0, idx = 0, last_acc = 0, dones = 0;
  bit stalled = 0;
  logic [11:0] st_a;
  logic [31:0] st_d;

  always @(negedge clk) begin
    if (rst) begin
      idx = 0; dones = 0; stalled = 0; last_acc = 0;
    end else if (mon_on) begin
      if (done_pulse) begin
        dones++; mchk++;
        if (idx != N || cyc != last_acc + 1) begin
          mfail++; $display("FAIL R9 done pulse: idx=%0d cyc=%0d expected idx=%0d cyc=%0d", idx, cyc, N, last_acc + 1);
        end
      end
      if (wr_valid) begin
        if (stalled) begin
          mchk++;
          if (wr_addr != st_a || wr_data != st_d) begin
            mfail++; $display("FAIL R8 hold: got %h/%h expected %h/%h", wr_addr, wr_data, st_a, st_d);
          end
        end
        if (wr_ready) begin
          mchk++;
          if (idx >= N) begin
            mfail++; $display("FAIL R10 extra write idx=%0d expected none", idx);
          end else begin
            if (wr_addr != exp_addr(idx)) begin
              mfail++; $display("FAIL R2/R3/R4/R7 step %0d addr %h expected %h", idx, wr_addr, exp_addr(idx));
            end
            mchk++;
            if (wr_data != exp_data(idx)) begin
              mfail++; $display("FAIL R2/R3/R4/R5/R7 step %0d data %h expected %h", idx, wr_data, exp_data(idx));
            end
            if (idx > 0) begin
              automatic int g = cyc - last_acc;
              automatic int eg = step_waits(idx - 1) ? W + 1 : 1;
              mchk++;
              if ((mode == 0 && g != eg) || (mode != 0 && g < eg)) begin
                mfail++; $display("FAIL R6 gap before step %0d: %0d expected %0d", idx, g, eg);
              end
            end
          end
          idx++; last_acc = cyc; stalled = 0;
        end else begin
          stalled = 1; st_a = wr_addr; st_d = wr_data;
        end
      end else if (stalled) begin
        mchk++; mfail++; stalled = 0;
        $display("FAIL R8 valid dropped while stalled: got 0 expected 1");
      end
    end
  end

  int chk = 0, fail = 0;

  task automatic expect_eq(input string tag, input int act, input int exp);
    chk++;
    if (act != exp) begin
      fail++; $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 2000 && !init_done; k++) @(negedge clk);
  endtask

  task automatic summary(input int extra);
    $display("TB_RESULT checks=%0d failures=%0d", chk + mchk + extra, fail + mfail + extra);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    summary(1);
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state, and nothing happens without start
    expect_eq("R1 valid in reset", int'(wr_valid), 0);
    rst = 0;
    mon_on = 1;
    repeat (6) @(negedge clk);
    expect_eq("R1 idle valid", int'(wr_valid), 0);
    expect_eq("R1 idle done", int'(init_done), 0);
    expect_eq("R1 idle pulse", int'(done_pulse), 0);

    // Run 1: ready always high, start re-pulsed mid-run (R10)
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    wait_done();
    @(negedge clk);
    expect_eq("R9 init_done run1", int'(init_done), 1);
    expect_eq("R4 writes run1", idx, N);
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (30) @(negedge clk);
    expect_eq("R10 no writes after done", idx, N);
    expect_eq("R9 one done pulse", dones, 1);
    expect_eq("R9 init_done held", int'(init_done), 1);

    // Run 2: back-pressure
    rst = 1; @(negedge clk); mode = 1; rst = 0;
    pulse_start();
    wait_done();
    @(negedge clk);
    expect_eq("R8 writes under back-pressure", idx, N);
    expect_eq("R9 one done pulse run2", dones, 1);

    // Run 3: reset mid-sequence, then restart (R11)
    rst = 1; @(negedge clk); mode = 0; rst = 0;
    pulse_start();
    for (int k = 0; k < 500 && idx < 6; k++) @(negedge clk);
    rst = 1;
    @(negedge clk);
    expect_eq("R11 valid low in reset", int'(wr_valid), 0);
    expect_eq("R11 init_done low in reset", int'(init_done), 0);
    rst = 0;
    repeat (5) @(negedge clk);
    expect_eq("R11 idle after reset", int'(wr_valid), 0);
    pulse_start();
    wait_done();
    @(negedge clk);
    expect_eq("R11 full replay", idx, N);
    expect_eq("R11 done after replay", dones, 1);
    summary(0);
  end

endmodule